// File: doc/BRIEF.md
# SDRAM Single-Word Access Sequencer

The sequencer takes one read or write at a time from a host port and converts it into the command sequence a 32-bit, four-bank SDRAM expects. A linear 21-bit word address is split into column, bank and row fields. The row is opened with ACTIVE. After a programmable row-to-column delay, a READ or WRITE follows with the auto-precharge flag set, so every access closes its own row. Read data is captured after the configured CAS latency and returned with a one-cycle valid strobe. Byte masks from the host drive the four data-mask lines on both reads and writes.

An external refresh unit requests the bus with a request/grant handshake. The grant is given only after the sequencer has gone idle, has issued a PRECHARGE to all banks and has waited the precharge time. While the grant is held, the command bus is deselected. All command, address and data outputs are registered and change on the rising clock edge.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is applied, chip select is high, grant, read-valid and the data-output enable are low. After reset is released with no refresh request, host_busy is low.
- R2: Address split: host_addr[7:0] is the column, [9:8] the bank and [20:10] the row. ACTIVE carries the bank on sd_ba and the row on sd_addr[10:0]. The column command carries the same bank and the column on sd_addr[7:0].
- R3: Every READ and WRITE is issued with sd_addr[10] high (auto precharge) and sd_addr[9:8] low.
- R4: The column command follows ACTIVE by exactly T_RCD clock cycles. Only NOP commands (CS#=0, RAS#=CAS#=WE#=1) lie between them.
- R5: On a write, sd_dq_oe is high in the WRITE command cycle only, and sd_dq_out holds the host data there. sd_dqm equals the host mask there: bit i covers data bits 8i+7:8i, and a 1 blocks that byte.
- R6: On a read, data is sampled at the CAS_LAT-th rising edge after the edge that registers READ. host_rvalid is high for one cycle with that word, CAS_LAT+1 cycles after the READ cycle.
- R7: On a read, sd_dqm carries the host mask from the ACTIVE cycle through the capture edge, which covers the two-clock read mask latency. Masked bytes of host_rdata read as zero.
- R8: host_busy is high from the acceptance edge until the access ends. An ACTIVE comes no sooner than T_WR+T_RP cycles after the previous WRITE.
- R9: On a refresh request while idle, a PRECHARGE with sd_addr[10] high (all banks) is issued. ref_gnt rises T_RP cycles later and holds while ref_req stays high. sd_cs_n is high throughout the grant.
- R10: A refresh request takes priority over a host request seen in the same idle cycle, and host_busy is high while ref_req is high. A refresh requested during an access is granted only after that access has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, taken when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Linear word address |
| host_wdata | input | 32 | Write data |
| host_mask | input | 4 | Byte mask, 1 blocks/blanks that byte |
| host_busy | output | 1 | Sequencer cannot take a request |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 32 | Read data |
| ref_req | input | 1 | Refresh unit wants the bus |
| ref_gnt | output | 1 | Bus handed to refresh unit |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 11 | Row / column / flag address |
| sd_dqm | output | 4 | Data mask per byte lane |
| sd_dq_out | output | 32 | Data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data from memory |

## Verification
The hardest case is a refresh request that lands on the same idle cycle as a host request, so that the arbitration order decides the outcome. A close second is a request that arrives in the middle of a read, while the capture is still outstanding. The bench raises ref_req and host_req in the same falling-edge slot. It then checks that the all-bank PRECHARGE and the grant come before any ACTIVE, and that the held host write runs only after the grant is dropped. For the mid-access case it raises ref_req one cycle after a read is accepted. It then checks that the read-data scoreboard is empty when ref_gnt first rises. A memory model on the bench side applies the read mask with a two-clock delay and fills blocked lanes with a marker byte, so any leak of a masked lane shows up as a mismatch.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int DATA_W  = 32,
  parameter int COL_W   = 8,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 11,
  parameter int AP_BIT  = 10,
  parameter int CAS_LAT = 2,
  parameter int T_RCD   = 2,
  parameter int T_WR    = 2,
  parameter int T_RP    = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            host_req,
  input  logic                            host_we,
  input  logic [ROW_W+BANK_W+COL_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]               host_wdata,
  input  logic [DATA_W/8-1:0]             host_mask,
  output logic                            host_busy,
  output logic                            host_rvalid,
  output logic [DATA_W-1:0]               host_rdata,
  input  logic                            ref_req,
  output logic                            ref_gnt,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr,
  output logic [DATA_W/8-1:0]             sd_dqm,
  output logic [DATA_W-1:0]               sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DATA_W-1:0]               sd_dq_in
);
  localparam int NBYTE = DATA_W / 8;
  localparam int AW    = ROW_W + BANK_W + COL_W;
  localparam int MAXC  = (T_WR + T_RP > CAS_LAT) ? ((T_WR + T_RP > T_RCD) ? T_WR + T_RP : T_RCD)
                                                 : ((CAS_LAT > T_RCD) ? CAS_LAT : T_RCD);
  localparam int CW    = $clog2(MAXC + 1) + 1;
  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_ACT   = 4'b0011;
  localparam logic [3:0] C_RD    = 4'b0101;
  localparam logic [3:0] C_WR    = 4'b0100;
  localparam logic [3:0] C_PRE   = 4'b0010;

  typedef enum logic [2:0] {S_IDLE, S_RCD, S_CAS, S_REC, S_PRE, S_REF} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [3:0]        cmd;
  logic              we_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NBYTE-1:0]  mask_q;
  logic [DATA_W-1:0] keep;
  logic [ROW_W-1:0]  col_word;

  for (genvar i = 0; i < NBYTE; i++) begin : g_lane
    assign keep[8*i +: 8] = {8{~mask_q[i]}};
  end

  assign col_word  = ROW_W'(addr_q[COL_W-1:0]) | AP_MASK;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign host_busy = (state != S_IDLE) || ref_req;
  assign ref_gnt   = (state == S_REF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      cmd         <= C_DESEL;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      mask_q      <= '0;
      sd_ba       <= '0;
      sd_addr     <= '0;
      sd_dqm      <= '0;
      sd_dq_out   <= '0;
      sd_dq_oe    <= 1'b0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      cmd         <= C_NOP;
      sd_dq_oe    <= 1'b0;
      host_rvalid <= 1'b0;
      case (state)
        S_IDLE: begin
          sd_dqm <= '0;
          if (ref_req) begin
            cmd     <= C_PRE;
            sd_addr <= AP_MASK;
            cnt     <= CW'(T_RP - 1);
            state   <= S_PRE;
          end else if (host_req) begin
            we_q    <= host_we;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            mask_q  <= host_mask;
            cmd     <= C_ACT;
            sd_ba   <= host_addr[COL_W +: BANK_W];
            sd_addr <= host_addr[COL_W+BANK_W +: ROW_W];
            sd_dqm  <= host_we ? '0 : host_mask;
            cnt     <= CW'(T_RCD - 1);
            state   <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            sd_addr <= col_word;
            if (we_q) begin
              cmd       <= C_WR;
              sd_dq_oe  <= 1'b1;
              sd_dq_out <= wdata_q;
              sd_dqm    <= mask_q;
              cnt       <= CW'(T_WR + T_RP - 1);
              state     <= S_REC;
            end else begin
              cmd   <= C_RD;
              cnt   <= CW'(CAS_LAT);
              state <= S_CAS;
            end
          end
        end
        S_CAS: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            host_rvalid <= 1'b1;
            host_rdata  <= sd_dq_in & keep;
            sd_dqm      <= '0;
            cnt         <= CW'(T_RP - 1);
            state       <= S_REC;
          end
        end
        S_REC: begin
          sd_dqm <= '0;
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           state <= S_IDLE;
        end
        S_PRE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cmd   <= C_DESEL;
            state <= S_REF;
          end
        end
        S_REF: begin
          if (ref_req) cmd   <= C_DESEL;
          else         state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module sdram_cmd_seq_chk #(
  parameter int ROW_W   = 11,
  parameter int AP_BIT  = 10,
  parameter int CAS_LAT = 2,
  parameter int T_RCD   = 2,
  parameter int T_WR    = 2,
  parameter int T_RP    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_busy,
  input logic             host_rvalid,
  input logic             ref_gnt,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe
);
  logic [3:0] c;
  logic       is_act, is_col, is_wr, is_rd, is_pre;
  logic [7:0] since_act, since_wr, since_rd;

  assign c      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (c == 4'b0011);
  assign is_rd  = (c == 4'b0101);
  assign is_wr  = (c == 4'b0100);
  assign is_col = is_rd || is_wr;
  assign is_pre = (c == 4'b0010);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 8'hff;
      since_wr  <= 8'hff;
      since_rd  <= 8'hff;
    end else begin
      since_act <= is_act ? 8'd1 : (since_act == 8'hff ? since_act : since_act + 8'd1);
      since_wr  <= is_wr  ? 8'd1 : (since_wr  == 8'hff ? since_wr  : since_wr  + 8'd1);
      since_rd  <= is_rd  ? 8'd1 : (since_rd  == 8'hff ? since_rd  : since_rd  + 8'd1);
    end
  end

  AST_COL_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n) is_col |-> sd_addr[AP_BIT]); // R3
  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) is_col |-> since_act == 8'(T_RCD)); // R4
  AST_OE_WRITE:    assert property (@(posedge clk) disable iff (!rst_n) sd_dq_oe |-> is_wr); // R5
  AST_CAS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) host_rvalid |-> since_rd == 8'(CAS_LAT + 1)); // R6
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) host_rvalid |=> !host_rvalid); // R6
  AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> host_busy); // R8
  AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> since_wr >= 8'(T_WR + T_RP)); // R8
  AST_PRE_ALL:     assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> sd_addr[AP_BIT]); // R9
  AST_GNT_DESEL:   assert property (@(posedge clk) disable iff (!rst_n) ref_gnt |-> sd_cs_n); // R9
  AST_GNT_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) ref_gnt |-> host_busy); // R10
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .ROW_W(ROW_W), .AP_BIT(AP_BIT), .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .host_rvalid(host_rvalid), .ref_gnt(ref_gnt),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe)
);

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int CL = 2, RCD = 2, WR = 2, RP = 2;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [20:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  host_mask = '0;
  logic host_busy, host_rvalid, ref_gnt;
  logic [31:0] host_rdata;
  logic ref_req = 0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [10:0] sd_addr;
  logic [3:0] sd_dqm;
  logic [31:0] sd_dq_out;
  logic [31:0] sd_dq_in = 32'h5a5a5a5a;

  always #4 clk = ~clk;

  sdram_cmd_seq #(.CAS_LAT(CL), .T_RCD(RCD), .T_WR(WR), .T_RP(RP)) i_sdram_cmd_seq (.*);

  typedef struct { logic we; logic [20:0] addr; logic [31:0] data; logic [3:0] mask; } acc_t;
  acc_t        exp_acc[$];
  logic [31:0] exp_rd[$];
  logic [3:0]  exp_rmask[$];
  logic [31:0] ref_mem[int];
  logic [31:0] arr[int];
  logic [10:0] open_row[4];

  int checks = 0, fails = 0;
  int cyc = 0, since_act = 99, since_wr = 99, rd_cnt = 0, rd_key = 0, rd_issue = 0;
  int pre_cyc = 0, gnt_seen = 0;
  bit act_open = 0, gnt_q = 0, timed_out = 0;
  logic [3:0] dqm_h1 = 0, dqm_h2 = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_of(input logic [3:0] m);
    for (int i = 0; i < 4; i++) keep_of[8*i +: 8] = {8{~m[i]}};
  endfunction

  task automatic set_req(input bit we, input logic [20:0] a, input logic [31:0] d, input logic [3:0] m);
    logic [31:0] old;
    host_req = 1; host_we = we; host_addr = a; host_wdata = d; host_mask = m;
    exp_acc.push_back('{we, a, d, m});
    old = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 32'h0;
    if (we) ref_mem[int'(a)] = (old & keep_of(~m)) | (d & keep_of(m));
    else begin exp_rd.push_back(old & keep_of(m)); exp_rmask.push_back(m); end
  endtask

  task automatic access(input bit we, input logic [20:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    while (host_busy) @(negedge clk);
    set_req(we, a, d, m);
    @(negedge clk);
    chk(host_busy, "R8 busy after accept", 32'(host_busy), 1);
    host_req = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (host_busy || exp_rd.size() != 0 || exp_acc.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    logic [3:0] c;
    acc_t e;
    logic [31:0] got;
    if (rst_n) begin
      cyc++; since_act++; since_wr++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          got = arr.exists(rd_key) ? arr[rd_key] : 32'h0;
          for (int i = 0; i < 4; i++) if (dqm_h2[i]) got[8*i +: 8] = 8'ha5;
          sd_dq_in = got;
        end else sd_dq_in = 32'h5a5a5a5a;
      end else sd_dq_in = 32'h5a5a5a5a;
      if (act_open && c != 4'b0111 && c != 4'b0101 && c != 4'b0100)
        chk(0, "R4 non-NOP between ACTIVE and column", 32'(c), 32'h7);
      if (sd_dq_oe && c != 4'b0100) chk(0, "R5 oe outside WRITE", 32'(c), 32'h4);
      case (c)
        4'b0011: begin
          chk(exp_acc.size() > 0, "R2 unexpected ACTIVE", 0, 1);
          if (exp_acc.size() > 0) begin
            e = exp_acc[0];
            chk(sd_ba == e.addr[9:8] && sd_addr == e.addr[20:10], "R2 ACTIVE bank/row",
                {19'd0, sd_ba, sd_addr}, {19'd0, e.addr[9:8], e.addr[20:10]});
          end
          chk(since_wr >= WR + RP, "R8 write recovery", since_wr, WR + RP);
          since_act = 0; act_open = 1; open_row[sd_ba] = sd_addr;
        end
        4'b0101, 4'b0100: begin
          act_open = 0;
          chk(since_act == RCD, "R4 ACTIVE to column", since_act, RCD);
          chk(sd_addr[10:8] == 3'b100, "R3 A10 auto precharge", 32'(sd_addr[10:8]), 32'h4);
          if (exp_acc.size() > 0) begin
            e = exp_acc.pop_front();
            chk(sd_ba == e.addr[9:8] && sd_addr[7:0] == e.addr[7:0] && (c == 4'b0100) == e.we,
                "R2 column bank/col", {22'd0, sd_ba, sd_addr[7:0]}, {22'd0, e.addr[9:8], e.addr[7:0]});
            if (c == 4'b0100) begin
              chk(sd_dq_oe && sd_dq_out == e.data, "R5 write data", sd_dq_out, e.data);
              chk(sd_dqm == e.mask, "R5 write mask", 32'(sd_dqm), 32'(e.mask));
            end
          end
          rd_key = int'({open_row[sd_ba], sd_ba, sd_addr[7:0]});
          if (c == 4'b0100) begin
            got = arr.exists(rd_key) ? arr[rd_key] : 32'h0;
            for (int i = 0; i < 4; i++) if (!sd_dqm[i]) got[8*i +: 8] = sd_dq_out[8*i +: 8];
            arr[rd_key] = got;
            since_wr = 0;
          end else begin
            rd_cnt = CL; rd_issue = cyc;
          end
        end
        4'b0010: begin
          chk(sd_addr[10], "R9 precharge all banks", 32'(sd_addr[10]), 1);
          pre_cyc = cyc;
        end
        default: ;
      endcase
      if (host_rvalid) begin
        chk(cyc - rd_issue == CL + 1, "R6 read latency", cyc - rd_issue, CL + 1);
        chk(exp_rd.size() > 0, "R6 unexpected rvalid", 0, 1);
        if (exp_rd.size() > 0) begin
          got = exp_rd.pop_front();
          if (exp_rmask.pop_front() != 0) chk(host_rdata == got, "R7 masked read data", host_rdata, got);
          else chk(host_rdata == got, "R6 read data", host_rdata, got);
        end
      end
      if (ref_gnt) begin
        chk(sd_cs_n, "R9 deselect during grant", 32'(sd_cs_n), 1);
        chk(host_busy, "R10 busy during grant", 32'(host_busy), 1);
        if (!gnt_q) begin
          chk(cyc - pre_cyc == RP, "R9 precharge to grant", cyc - pre_cyc, RP);
          gnt_seen++;
        end
      end
      gnt_q = ref_gnt;
      dqm_h2 = dqm_h1; dqm_h1 = sd_dqm;
    end
  end

  task automatic run();
    repeat (3) @(negedge clk);
    chk(sd_cs_n && !ref_gnt && !host_rvalid && !sd_dq_oe, "R1 reset outputs",
        {sd_cs_n, ref_gnt, host_rvalid, sd_dq_oe}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(!host_busy, "R1 idle after reset", 32'(host_busy), 0);

    access(1, 21'h000123, 32'h11223344, 4'h0);
    access(0, 21'h000123, 32'h0, 4'h0);
    access(1, 21'h000123, 32'hAABBCCDD, 4'b0101);
    access(0, 21'h000123, 32'h0, 4'h0);
    access(0, 21'h000123, 32'h0, 4'b1000);
    access(1, 21'h1FFFFF, 32'hCAFEF00D, 4'h0);
    access(1, 21'h000000, 32'h01020304, 4'h0);
    access(1, 21'h1FFEFF, 32'h0BADBEEF, 4'h0);
    access(0, 21'h1FFFFF, 32'h0, 4'b0011);
    access(0, 21'h000000, 32'h0, 4'h0);
    access(0, 21'h1FFEFF, 32'h0, 4'h0);
    access(0, 21'h0ABCDE, 32'h0, 4'h0);
    for (int k = 0; k < 8; k++) access(1, 21'(k * 21'h2345), 32'h9000_0000 + k, 4'(k));
    for (int k = 0; k < 8; k++) access(0, 21'(k * 21'h2345), 32'h0, 4'(k ^ 4'h3));
    drain();

    @(negedge clk);
    ref_req = 1;
    set_req(1, 21'h012345, 32'h77778888, 4'h0);
    while (!ref_gnt) @(negedge clk);
    chk(exp_acc.size() == 1, "R10 refresh wins same-cycle request", exp_acc.size(), 1);
    repeat (4) @(negedge clk);
    chk(ref_gnt && exp_acc.size() == 1, "R9 grant held", {ref_gnt, 8'(exp_acc.size())}, 32'h101);
    ref_req = 0;
    @(negedge clk);
    @(negedge clk);
    host_req = 0;
    drain();
    access(0, 21'h012345, 32'h0, 4'h0);

    access(0, 21'h000123, 32'h0, 4'h0);
    ref_req = 1;
    while (!ref_gnt) @(negedge clk);
    chk(exp_rd.size() == 0, "R10 grant after access completes", exp_rd.size(), 0);
    @(negedge clk);
    ref_req = 0;
    drain();
    chk(gnt_seen == 2, "R9 grant count", gnt_seen, 2);
  endtask

  initial begin
    fork
      run();
      begin repeat (100000) @(posedge clk); timed_out = 1; end
    join_any
    if (timed_out) chk(0, "R8 watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule